// File: doc/BRIEF.md
# Configurable Asynchronous Serial Frame Transmitter

This block turns one data word into an asynchronous serial frame on a single output line. A frame starts with a low start bit. The data bits follow, then an optional parity bit, then zero, one or two high stop bits. Four control inputs set the shape of each frame: a length code, a bit-order select, a parity mode and a stop-bit count.

The surrounding logic supplies a baud tick that is high for one clock cycle per bit period. It also supplies the data word, the format fields and a one-cycle start strobe. When the block accepts a start, it captures the word and the format together. It then shifts the frame out, one bit per tick, and reports the end of the frame with a one-cycle pulse. The block does not generate the baud rate. It has no buffering.

Top module: `async_frame_tx`

## Requirements
- R1: After reset, and at all times while no frame is in progress, `txd` is 1 and `busy` is 0. During reset and in the first cycle after it, `done` and `fmt_err` are 0.
- R2: A start accepted while idle makes `busy` 1 in the next cycle, and `txd` stays high until the first baud tick. That tick drives the low start bit. Each later tick moves the frame on by exactly one bit, and `txd` does not change between ticks.
- R3: `len_code` 3'b100 sends 5 data bits, 3'b110 sends 7 and 3'b111 sends 8. The bits come from `data_in[L-1:0]`, and the word's upper bits have no effect on the line.
- R4: `lsb_first` = 0 sends the selected data bits MSB first. `lsb_first` = 1 sends them LSB first.
- R5: `par_mode` 2'b00 sends no parity bit and 2'b01 sends a parity bit of 0. 2'b10 sends even parity: the bit is the XOR of the selected data bits. 2'b11 sends odd parity, the inverse of that XOR. The parity bit follows the last data bit.
- R6: `stop_sel` 2'b00 sends no stop bit, 2'b01 sends one high stop bit and 2'b10 sends two.
- R7: On the tick that ends the period of the frame's last bit, `done` pulses for exactly one cycle. In that same cycle `busy` falls and `txd` returns high. With no stop bits, the last bit is the last data or parity bit.
- R8: A start that arrives while idle with `stop_sel` = 2'b11, or with a `len_code` other than 100, 110 or 111, starts no frame. Instead `fmt_err` is 1 for exactly the next cycle.
- R9: A start strobe that arrives while `busy` is 1 is ignored. The frame in progress goes on unchanged, and no second frame follows it.
- R10: The data word and all format fields are captured when the start is accepted. Changing them during the frame does not alter it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_tick | input | 1 | One-cycle pulse per bit period |
| start | input | 1 | Request to send `data_in` |
| data_in | input | DATA_W | Word to send; the low bits are used |
| len_code | input | 3 | Data length code |
| par_mode | input | 2 | Parity mode |
| lsb_first | input | 1 | Bit order select |
| stop_sel | input | 2 | Stop-bit count select |
| txd | output | 1 | Serial line, idles high |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |
| fmt_err | output | 1 | One-cycle pulse for a rejected format |

## Verification
The assertions check these properties on every cycle:
- the line is high whenever the block is idle;
- `txd` holds steady between baud ticks;
- `done` and `fmt_err` are single-cycle pulses, and each one occurs only in an idle cycle;
- a frame starts only from a legal format.

Only the bench's scenarios can show that the bit sequence itself is right. That covers the data order, the parity values, the length and stop-bit counts, and the independence from the word's upper bits. The same holds for ignoring a start during a frame and for capturing the format at acceptance. The bench checks these by comparing the captured line against frames it builds from the requirements.

// File: rtl/aft_pkg.sv
package aft_pkg;

   typedef enum logic [1:0] {
      PAR_NONE = 2'b00,
      PAR_ZERO = 2'b01,
      PAR_EVEN = 2'b10,
      PAR_ODD  = 2'b11
   } par_mode_e;

   localparam logic [2:0] LEN_CODE_5 = 3'b100;
   localparam logic [2:0] LEN_CODE_7 = 3'b110;
   localparam logic [2:0] LEN_CODE_8 = 3'b111;

   localparam logic [1:0] STOP_CODE_0 = 2'b00;
   localparam logic [1:0] STOP_CODE_1 = 2'b01;
   localparam logic [1:0] STOP_CODE_2 = 2'b10;

endpackage

// File: rtl/aft_fmt_decode.sv
module aft_fmt_decode #(
   parameter int LEN_W  = 4,
   parameter int STOP_W = 2
) (
   input  logic [2:0]        len_code,
   input  logic [1:0]        stop_sel,
   output logic [LEN_W-1:0]  data_len,
   output logic [STOP_W-1:0] stop_cnt,
   output logic              legal
);
   import aft_pkg::*;

   logic len_ok;
   logic stop_ok;

   always_comb begin
      len_ok = 1'b1;
      unique case (len_code)
         LEN_CODE_5: data_len = LEN_W'(5);
         LEN_CODE_7: data_len = LEN_W'(7);
         LEN_CODE_8: data_len = LEN_W'(8);
         default: begin
            data_len = LEN_W'(8);
            len_ok   = 1'b0;
         end
      endcase
   end

   always_comb begin
      stop_ok = 1'b1;
      unique case (stop_sel)
         STOP_CODE_0: stop_cnt = STOP_W'(0);
         STOP_CODE_1: stop_cnt = STOP_W'(1);
         STOP_CODE_2: stop_cnt = STOP_W'(2);
         default: begin
            stop_cnt = STOP_W'(0);
            stop_ok  = 1'b0;
         end
      endcase
   end

   assign legal = len_ok & stop_ok;

endmodule

// File: rtl/aft_frame_build.sv
module aft_frame_build #(
   parameter int DATA_W  = 8,
   parameter int LEN_W   = 4,
   parameter int STOP_W  = 2,
   parameter int FRAME_W = 12,
   parameter int CNT_W   = 4
) (
   input  logic [DATA_W-1:0]  data,
   input  logic [LEN_W-1:0]   data_len,
   input  logic               lsb_first,
   input  aft_pkg::par_mode_e par_mode,
   input  logic [STOP_W-1:0]  stop_cnt,
   output logic [FRAME_W-1:0] frame,
   output logic [CNT_W-1:0]   nbits
);
   import aft_pkg::*;

   logic [DATA_W-1:0] masked;
   logic [DATA_W-1:0] ordered;
   logic              has_par;
   logic              pbit;

   // masked: only the selected low bits; ordered: line order of data bits
   always_comb begin
      for (int i = 0; i < DATA_W; i++) begin
         masked[i]  = (i < int'(data_len)) ? data[i] : 1'b0;
         ordered[i] = 1'b0;
         for (int j = 0; j < DATA_W; j++) begin
            if (lsb_first ? (j == i) : (i + j + 1 == int'(data_len)))
               ordered[i] = data[j];
         end
      end
   end

   always_comb begin
      unique case (par_mode)
         PAR_ZERO: pbit = 1'b0;
         PAR_EVEN: pbit = ^masked;
         PAR_ODD:  pbit = ~(^masked);
         default:  pbit = 1'b1;
      endcase
   end

   assign has_par = (par_mode != PAR_NONE);

   // position 0 is the start bit; positions past the payload read as stop level
   assign frame[0] = 1'b0;
   for (genvar p = 1; p < FRAME_W; p++) begin : g_pos
      localparam int K = p - 1;
      if (K < DATA_W) begin : g_data
         assign frame[p] = (K < int'(data_len)) ? ordered[K] :
                           ((has_par && (K == int'(data_len))) ? pbit : 1'b1);
      end else begin : g_tail
         assign frame[p] = (has_par && (K == int'(data_len))) ? pbit : 1'b1;
      end
   end

   assign nbits = CNT_W'(1) + CNT_W'(data_len) + CNT_W'(has_par) + CNT_W'(stop_cnt);

endmodule

// File: rtl/aft_bit_engine.sv
module aft_bit_engine #(
   parameter int FRAME_W = 12,
   parameter int CNT_W   = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               baud_tick,
   input  logic               load,
   input  logic [FRAME_W-1:0] frame,
   input  logic [CNT_W-1:0]   nbits,
   output logic               txd,
   output logic               busy,
   output logic               done
);
   logic [FRAME_W-1:0] shreg;
   logic [CNT_W-1:0]   left;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shreg <= '1;
         left  <= '0;
         busy  <= 1'b0;
         txd   <= 1'b1;
         done  <= 1'b0;
      end else begin
         done <= 1'b0;
         if (!busy) begin
            if (load) begin
               shreg <= frame;
               left  <= nbits;
               busy  <= 1'b1;
            end
         end else if (baud_tick) begin
            if (left != '0) begin
               txd   <= shreg[0];
               shreg <= {1'b1, shreg[FRAME_W-1:1]};
               left  <= left - CNT_W'(1);
            end else begin
               txd  <= 1'b1;
               busy <= 1'b0;
               done <= 1'b1;
            end
         end
      end
   end

   p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> txd);

   p_hold_between_ticks_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !baud_tick) |=> $stable(txd));

   p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_done_ends_frame_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && txd && $past(busy)));

endmodule

// File: rtl/async_frame_tx.sv
module async_frame_tx #(
   parameter int DATA_W   = 8,
   parameter int STOP_MAX = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              baud_tick,
   input  logic              start,
   input  logic [DATA_W-1:0] data_in,
   input  logic [2:0]        len_code,
   input  logic [1:0]        par_mode,
   input  logic              lsb_first,
   input  logic [1:0]        stop_sel,
   output logic              txd,
   output logic              busy,
   output logic              done,
   output logic              fmt_err
);
   import aft_pkg::*;

   localparam int LEN_W   = $clog2(DATA_W + 1);
   localparam int STOP_W  = $clog2(STOP_MAX + 1);
   localparam int FRAME_W = 2 + DATA_W + STOP_MAX;
   localparam int CNT_W   = $clog2(FRAME_W + 1);

   if (DATA_W < 8) begin : g_chk_width
      $error("async_frame_tx: DATA_W must be at least 8");
   end
   if (STOP_MAX < 2) begin : g_chk_stop
      $error("async_frame_tx: STOP_MAX must be at least 2");
   end

   logic [LEN_W-1:0]   data_len;
   logic [STOP_W-1:0]  stop_cnt;
   logic               fmt_legal;
   logic [FRAME_W-1:0] frame;
   logic [CNT_W-1:0]   nbits;
   logic               accept;
   par_mode_e          pmode;

   assign pmode  = par_mode_e'(par_mode);
   assign accept = start && !busy && fmt_legal;

   aft_fmt_decode #(.LEN_W(LEN_W), .STOP_W(STOP_W)) u_dec (
      .len_code (len_code),
      .stop_sel (stop_sel),
      .data_len (data_len),
      .stop_cnt (stop_cnt),
      .legal    (fmt_legal)
   );

   aft_frame_build #(
      .DATA_W(DATA_W), .LEN_W(LEN_W), .STOP_W(STOP_W),
      .FRAME_W(FRAME_W), .CNT_W(CNT_W)
   ) u_build (
      .data      (data_in),
      .data_len  (data_len),
      .lsb_first (lsb_first),
      .par_mode  (pmode),
      .stop_cnt  (stop_cnt),
      .frame     (frame),
      .nbits     (nbits)
   );

   aft_bit_engine #(.FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_eng (
      .clk       (clk),
      .rst_n     (rst_n),
      .baud_tick (baud_tick),
      .load      (accept),
      .frame     (frame),
      .nbits     (nbits),
      .txd       (txd),
      .busy      (busy),
      .done      (done)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) fmt_err <= 1'b0;
      else        fmt_err <= start && !busy && !fmt_legal;
   end

   p_err_when_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      fmt_err |-> (!busy && txd));

   p_err_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      fmt_err |=> !fmt_err);

   p_frame_needs_legal_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(fmt_legal && start));

   p_flags_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({done, fmt_err}));

   p_start_while_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !baud_tick) |=> (busy && !fmt_err));

endmodule

// File: tb/sim_async_frame_tx.sv
module sim_async_frame_tx;

   localparam int DIV = 4;
   localparam int WD  = 100000;
   localparam int NV  = 8;

   // {data[19:12], len[11:9], par[8:7], lsb[6], stop[5:4], expected bits[3:0]}
   localparam logic [19:0] VEC [NV] = '{
      {8'hA5, 3'b111, 2'b00, 1'b0, 2'b01, 4'd10},
      {8'hA5, 3'b111, 2'b10, 1'b1, 2'b01, 4'd11},
      {8'h3C, 3'b110, 2'b11, 1'b0, 2'b10, 4'd11},
      {8'hFF, 3'b100, 2'b01, 1'b1, 2'b00, 4'd7},
      {8'hE0, 3'b100, 2'b10, 1'b0, 2'b01, 4'd8},
      {8'h01, 3'b111, 2'b11, 1'b1, 2'b10, 4'd12},
      {8'h80, 3'b110, 2'b10, 1'b1, 2'b00, 4'd9},
      {8'h5A, 3'b111, 2'b01, 1'b0, 2'b10, 4'd12}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic [7:0] data_in = '0;
   logic [2:0] len_code = 3'b111;
   logic [1:0] par_mode = 2'b00;
   logic       lsb_first = 1'b0;
   logic [1:0] stop_sel = 2'b01;
   logic       baud_tick;
   logic       txd, busy, done, fmt_err;

   int         div_cnt = 0;
   logic       mon_en = 1'b0;
   logic       cap [16];
   int         cap_n = 0;
   int         n_tests = 0;
   int         n_fail = 0;

   always #10 clk = ~clk;

   assign baud_tick = (div_cnt == DIV - 1);

   always @(negedge clk) begin
      div_cnt <= (div_cnt == DIV - 1) ? 0 : div_cnt + 1;
      if (!mon_en) cap_n <= 0;
      else if (baud_tick && !done && cap_n < 16) begin
         cap[cap_n] <= txd;
         cap_n      <= cap_n + 1;
      end
   end

   async_frame_tx u0 (
      .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .start(start),
      .data_in(data_in), .len_code(len_code), .par_mode(par_mode),
      .lsb_first(lsb_first), .stop_sel(stop_sel),
      .txd(txd), .busy(busy), .done(done), .fmt_err(fmt_err)
   );

   initial begin
      repeat (WD) @(posedge clk);
      $display("FAIL watchdog: run hung, got %0d expected 0 cycles left", 0);
      $display("[TB] %0d tests run, %0d failed", n_tests + 1, n_fail + 1);
      $finish;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: got %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic build_exp(input logic [7:0] d, input logic [2:0] lc, input logic [1:0] pm,
                            input logic lb, input logic [1:0] sc,
                            output logic [15:0] e, output int n);
      int len;
      int ones;
      len  = (lc == 3'b100) ? 5 : (lc == 3'b110) ? 7 : 8;
      e    = '1;
      e[0] = 1'b0;
      n    = 1;
      ones = 0;
      for (int i = 0; i < len; i++) begin
         logic b;
         b = lb ? d[i] : d[len - 1 - i];
         e[n] = b;
         ones += int'(b);
         n++;
      end
      if (pm != 2'b00) begin
         e[n] = (pm == 2'b01) ? 1'b0 : (pm == 2'b10) ? ones[0] : ~ones[0];
         n++;
      end
      for (int i = 0; i < int'(sc); i++) begin
         e[n] = 1'b1;
         n++;
      end
   endtask

   task automatic run_frame(input logic [7:0] d, input logic [2:0] lc, input logic [1:0] pm,
                            input logic lb, input logic [1:0] sc, input int exp_n,
                            input bit disturb, input string tag);
      logic [15:0] e;
      logic [15:0] got;
      int          n;
      int          guard;
      int          mask;
      build_exp(d, lc, pm, lb, sc, e, n);
      do @(negedge clk); while (div_cnt != 0);
      data_in <= d; len_code <= lc; par_mode <= pm; lsb_first <= lb; stop_sel <= sc;
      start <= 1'b1;
      mon_en <= 1'b1;
      @(negedge clk);
      start <= 1'b0;
      chk(busy === 1'b1 && txd === 1'b1, {tag, " R2 busy/idle line after accept"},
          int'({busy, txd}), 3);
      if (disturb) begin
         repeat (6) @(negedge clk);
         data_in <= ~d; len_code <= 3'b100; par_mode <= ~pm; lsb_first <= ~lb;
         stop_sel <= 2'b00; start <= 1'b1;
         @(negedge clk);
         start <= 1'b0;
      end
      guard = 0;
      do begin
         @(negedge clk);
         guard++;
      end while (!done && guard < 400);
      mon_en <= 1'b0;
      chk(done === 1'b1 && busy === 1'b0 && txd === 1'b1,
          {tag, " R7 end of frame flags"}, int'({done, busy, txd}), 5);
      chk(cap_n == n && n == exp_n, {tag, " R3 R6 bit count"}, cap_n, exp_n);
      got = '1;
      for (int i = 0; i < cap_n && i < 16; i++) got[i] = cap[i];
      mask = (1 << n) - 1;
      chk((int'(got) & mask) == (int'(e) & mask), {tag, " R3 R4 R5 R6 bit pattern"},
          int'(got) & mask, int'(e) & mask);
      @(negedge clk);
      chk(done === 1'b0 && busy === 1'b0, {tag, " R7 single-cycle done"},
          int'({done, busy}), 0);
   endtask

   task automatic bad_fmt(input logic [2:0] lc, input logic [1:0] sc, input string tag);
      @(negedge clk);
      len_code <= lc; stop_sel <= sc; start <= 1'b1;
      @(negedge clk);
      start <= 1'b0;
      chk(fmt_err === 1'b1 && busy === 1'b0, {tag, " R8 error pulse"},
          int'({fmt_err, busy}), 2);
      @(negedge clk);
      chk(fmt_err === 1'b0 && busy === 1'b0 && txd === 1'b1, {tag, " R8 no frame"},
          int'({fmt_err, busy, txd}), 1);
      repeat (2 * DIV) @(negedge clk);
      chk(busy === 1'b0 && txd === 1'b1, {tag, " R8 line stays idle"},
          int'({busy, txd}), 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(txd === 1'b1 && busy === 1'b0 && done === 1'b0 && fmt_err === 1'b0,
          "R1 state in reset", int'({txd, busy, done, fmt_err}), 8);
      rst_n <= 1'b1;
      @(negedge clk);
      chk(txd === 1'b1 && busy === 1'b0 && done === 1'b0 && fmt_err === 1'b0,
          "R1 state after reset", int'({txd, busy, done, fmt_err}), 8);

      for (int v = 0; v < NV; v++) begin
         run_frame(VEC[v][19:12], VEC[v][11:9], VEC[v][8:7], VEC[v][6], VEC[v][5:4],
                   int'(VEC[v][3:0]), 1'b0, $sformatf("vec%0d", v));
      end

      // R9 and R10: restart request and format changes in mid-frame
      run_frame(8'hC3, 3'b111, 2'b10, 1'b0, 2'b10, 12, 1'b1, "mid-frame R9 R10");
      repeat (3 * DIV) @(negedge clk);
      chk(busy === 1'b0 && txd === 1'b1, "R9 no second frame", int'({busy, txd}), 1);

      bad_fmt(3'b111, 2'b11, "stop 11");
      bad_fmt(3'b101, 2'b01, "len 101");
      bad_fmt(3'b000, 2'b00, "len 000");

      // upper bits ignored: same low 5 bits, different upper bits, same frame
      run_frame(8'h1B, 3'b100, 2'b11, 1'b0, 2'b01, 8, 1'b0, "R3 low5");
      run_frame(8'hFB, 3'b100, 2'b11, 1'b0, 2'b01, 8, 1'b0, "R3 high bits set");

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule